// File: doc/BRIEF.md
# Conditional Skip Condition Evaluator

This block decides whether a 16-bit accumulator machine skips the next instruction word. On every execute strobe it looks at the instruction word. If the word belongs to the skip group, the block picks one of nine status sources with a one-hot selector field. Three of the sources are tests on the accumulator and link register. The other six are ready or status flags from the display processor, keyboard, serial receiver, serial transmitter, 40 Hz sync source and paper-tape unit. The top bit of the word sets the polarity of the test, so every source has a skip-when-true form and a skip-when-false form.

The result is a registered one-cycle pulse. The program counter logic uses it to add one extra word to the normal increment. A word that falls in the group without exactly one selector bit raises a separate illegal pulse and never skips. Every group instruction completes in one cycle. The block does not hold the program counter and does not clear any peripheral flags.

Top module: `skip_eval`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, both `skip_o` and `illegal_o` are low.
- R2: The block reacts only to words where `instr_i & 16'o077000 == 16'o002000`. Any other word leaves both outputs low on the next cycle.
- R3: Selector bit 0 (value 16'o000001) tests whether the accumulator is zero.
- R4: Selector bit 1 (value 16'o000002) tests whether accumulator bit 15 is clear, which means the value is positive.
- R5: Selector bit 2 (value 16'o000004) tests whether the link is zero.
- R6: Selector bits 3 to 8 (values 16'o010 through 16'o400) test, in that order, display running, keyboard ready, serial input ready, serial output ready, sync flag and tape ready. Sources that are not selected have no effect.
- R7: When instruction bit 15 is clear, the block skips if the condition holds. When bit 15 is set, it skips if the condition does not hold.
- R8: A group word whose selector field (bits 8:0) has zero bits set or more than one bit set raises `illegal_o` and does not skip.
- R9: Both outputs are registered. Each is valid for exactly the one cycle after the execute strobe and is low in any cycle that does not follow a strobe.
- R10: Inputs are sampled only in the strobe cycle. Changes to them in any other cycle do not affect the result.
- R11: `skip_o` and `illegal_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe, one cycle per instruction |
| instr_i | input | 16 | Instruction word being executed |
| acc_i | input | 16 | Current accumulator |
| link_i | input | 1 | Current link bit |
| disp_run_i | input | 1 | Display processor running |
| kbd_rdy_i | input | 1 | Keyboard has a character |
| rx_rdy_i | input | 1 | Serial input has a character |
| tx_rdy_i | input | 1 | Serial output can accept a character |
| sync_i | input | 1 | 40 Hz sync flag |
| tape_rdy_i | input | 1 | Paper-tape unit ready |
| skip_o | output | 1 | Skip the next word (one-cycle pulse) |
| illegal_o | output | 1 | Malformed skip-group word (one-cycle pulse) |

## Verification
The hardest case to reach from the ports is showing that a source which is not selected has no effect. In a normal test the selected source and the rest tend to agree, so a mux with a bad index could still give the right answer. The stimulus therefore drives every unselected flag to the opposite of the selected one in several vectors. Those vectors make a cross-wired source flip the expected result. A second hard case is the sampling window. The bench changes the link after the strobe edge but before it samples the pulse, and it also toggles inputs while the strobe is low, to show that only the strobe cycle counts.

// File: rtl/skip_pkg.sv
package skip_pkg;

  localparam int INSTR_W  = 16;
  localparam int NUM_SRC  = 9;
  localparam int SEL_LSB  = 0;
  localparam int INV_BIT  = 15;
  localparam logic [INSTR_W-1:0] GRP_MASK = 16'o077000;
  localparam logic [INSTR_W-1:0] GRP_CODE = 16'o002000;

  // Selector bit index of each condition source; the order is decoded.
  typedef enum int {
    SRC_ACC_ZERO  = 0,
    SRC_ACC_POS   = 1,
    SRC_LINK_ZERO = 2,
    SRC_DISP      = 3,
    SRC_KBD       = 4,
    SRC_RX        = 5,
    SRC_TX        = 6,
    SRC_SYNC      = 7,
    SRC_TAPE      = 8
  } src_idx_e;

  typedef struct packed {
    logic               grp;     // word lies in the skip group
    logic               single;  // exactly one selector bit set
    logic               invert;  // skip when condition is false
    logic [NUM_SRC-1:0] sel;     // one-hot source selector
  } dec_t;

  function automatic logic in_group(input logic [INSTR_W-1:0] w);
    return (w & GRP_MASK) == GRP_CODE;
  endfunction

  function automatic logic exactly_one(input logic [NUM_SRC-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < NUM_SRC; i++) n += int'(v[i]);
    return n == 1;
  endfunction

  function automatic logic skip_rule(input logic cond, input logic inv);
    return cond ^ inv;
  endfunction

endpackage

// File: rtl/skip_decode.sv
module skip_decode
  import skip_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  always_comb begin
    dec_o.grp    = in_group(instr_i);
    dec_o.sel    = instr_i[SEL_LSB +: NUM_SRC];
    dec_o.single = exactly_one(instr_i[SEL_LSB +: NUM_SRC]);
    dec_o.invert = instr_i[INV_BIT];
  end
endmodule

// File: rtl/skip_srcmux.sv
module skip_srcmux
  import skip_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic [ACC_W-1:0]   acc_i,
  input  logic               link_i,
  input  logic               disp_run_i,
  input  logic               kbd_rdy_i,
  input  logic               rx_rdy_i,
  input  logic               tx_rdy_i,
  input  logic               sync_i,
  input  logic               tape_rdy_i,
  input  logic [NUM_SRC-1:0] sel_i,
  output logic               cond_o
);
  localparam int SIGN = ACC_W - 1;

  logic [NUM_SRC-1:0] src;
  logic [NUM_SRC-1:0] hit;

  always_comb begin
    src                = '0;
    src[SRC_ACC_ZERO]  = (acc_i == '0);
    src[SRC_ACC_POS]   = ~acc_i[SIGN];
    src[SRC_LINK_ZERO] = ~link_i;
    src[SRC_DISP]      = disp_run_i;
    src[SRC_KBD]       = kbd_rdy_i;
    src[SRC_RX]        = rx_rdy_i;
    src[SRC_TX]        = tx_rdy_i;
    src[SRC_SYNC]      = sync_i;
    src[SRC_TAPE]      = tape_rdy_i;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_and
    assign hit[g] = sel_i[g] & src[g];
  end

  assign cond_o = |hit;
endmodule

// File: rtl/skip_outreg.sv
module skip_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic bad_i,
  input  logic take_i,
  output logic skip_o,
  output logic illegal_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      skip_o    <= fire_i & take_i;
      illegal_o <= bad_i;
    end
  end
endmodule

// File: rtl/skip_eval.sv
module skip_eval
  import skip_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ACC_W-1:0]   acc_i,
  input  logic               link_i,
  input  logic               disp_run_i,
  input  logic               kbd_rdy_i,
  input  logic               rx_rdy_i,
  input  logic               tx_rdy_i,
  input  logic               sync_i,
  input  logic               tape_rdy_i,
  output logic               skip_o,
  output logic               illegal_o
);
  dec_t dec;
  logic cond;
  logic legal_hit;  // strobe on a well-formed group word
  logic bad_hit;    // strobe on a malformed group word
  logic take;       // polarity-adjusted condition

  skip_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  skip_srcmux #(.ACC_W(ACC_W)) u_mux (
    .acc_i      (acc_i),
    .link_i     (link_i),
    .disp_run_i (disp_run_i),
    .kbd_rdy_i  (kbd_rdy_i),
    .rx_rdy_i   (rx_rdy_i),
    .tx_rdy_i   (tx_rdy_i),
    .sync_i     (sync_i),
    .tape_rdy_i (tape_rdy_i),
    .sel_i      (dec.sel),
    .cond_o     (cond)
  );

  assign legal_hit = exec_i & dec.grp & dec.single;
  assign bad_hit   = exec_i & dec.grp & ~dec.single;
  assign take      = skip_rule(cond, dec.invert);

  skip_outreg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (legal_hit),
    .bad_i     (bad_hit),
    .take_i    (take),
    .skip_o    (skip_o),
    .illegal_o (illegal_o)
  );
endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exec_i,
  input logic [15:0] instr_i,
  input logic [15:0] acc_i,
  input logic        link_i,
  input logic        skip_o,
  input logic        illegal_o
);
  logic grp_w;
  assign grp_w = (instr_i & 16'o077000) == 16'o002000;

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(skip_o && illegal_o));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> (!skip_o && !illegal_o));

  assert_outside_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !grp_w) |=> (!skip_o && !illegal_o));

  assert_badsel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && grp_w && $countones(instr_i[8:0]) != 1) |=> (illegal_o && !skip_o));

  assert_acczero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i == 16'o002001) |=> (skip_o == $past(acc_i == 16'h0000)));

  assert_linkset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i == 16'o102004) |=> (skip_o == $past(link_i)));

  assert_signneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i == 16'o102002) |=> (skip_o == $past(acc_i[15])));
endmodule

bind skip_eval skip_eval_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exec_i    (exec_i),
  .instr_i   (instr_i),
  .acc_i     (acc_i),
  .link_i    (link_i),
  .skip_o    (skip_o),
  .illegal_o (illegal_o)
);

// File: tb/test_skip_eval.sv
module test_skip_eval;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  // {instr[40:25], acc[24:9], link[8], dev[7:2] = disp,kbd,rx,tx,sync,tape, skip[1], ill[0]}
  localparam logic [40:0] VEC [NVEC] = '{
    {16'o002001, 16'h0000, 1'b0, 6'b000000, 1'b1, 1'b0},  // R3 zero
    {16'o002001, 16'h0005, 1'b0, 6'b111111, 1'b0, 1'b0},  // R3 nonzero
    {16'o102001, 16'h0005, 1'b0, 6'b000000, 1'b1, 1'b0},  // R7
    {16'o102001, 16'h0000, 1'b1, 6'b111111, 1'b0, 1'b0},  // R7
    {16'o002002, 16'h7fff, 1'b0, 6'b000000, 1'b1, 1'b0},  // R4
    {16'o002002, 16'h8000, 1'b0, 6'b111111, 1'b0, 1'b0},  // R4
    {16'o102002, 16'h8000, 1'b0, 6'b000000, 1'b1, 1'b0},  // R4 R7
    {16'o002004, 16'h0000, 1'b0, 6'b000000, 1'b1, 1'b0},  // R5
    {16'o002004, 16'h0000, 1'b1, 6'b111111, 1'b0, 1'b0},  // R5
    {16'o102004, 16'h1234, 1'b1, 6'b000000, 1'b1, 1'b0},  // R5 R7
    {16'o002010, 16'h1111, 1'b1, 6'b100000, 1'b1, 1'b0},  // R6 disp
    {16'o002010, 16'h0000, 1'b0, 6'b011111, 1'b0, 1'b0},  // R6 others ignored
    {16'o102020, 16'h0000, 1'b0, 6'b101111, 1'b1, 1'b0},  // R6 kbd R7
    {16'o002040, 16'h0001, 1'b1, 6'b001000, 1'b1, 1'b0},  // R6 rx
    {16'o002100, 16'h0001, 1'b1, 6'b000100, 1'b1, 1'b0},  // R6 tx
    {16'o102100, 16'h0001, 1'b1, 6'b000100, 1'b0, 1'b0},  // R6 tx R7
    {16'o002200, 16'h0001, 1'b1, 6'b000010, 1'b1, 1'b0},  // R6 sync
    {16'o002400, 16'h0001, 1'b1, 6'b000001, 1'b1, 1'b0},  // R6 tape
    {16'o102400, 16'h0000, 1'b0, 6'b111110, 1'b1, 1'b0},  // R6 tape R7
    {16'o002000, 16'h0000, 1'b0, 6'b111111, 1'b0, 1'b1},  // R8 empty
    {16'o102000, 16'h0000, 1'b1, 6'b000000, 1'b0, 1'b1},  // R8 empty
    {16'o002003, 16'h0000, 1'b0, 6'b111111, 1'b0, 1'b1},  // R8 multi
    {16'o002401, 16'h0000, 1'b0, 6'b111111, 1'b0, 1'b1},  // R8 multi
    {16'o000001, 16'h0000, 1'b0, 6'b111111, 1'b0, 1'b0},  // R2
    {16'o006001, 16'h0000, 1'b0, 6'b111111, 1'b0, 1'b0},  // R2
    {16'o012001, 16'h0000, 1'b0, 6'b111111, 1'b0, 1'b0}   // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [15:0] acc_i = '0;
  logic        link_i = 1'b0;
  logic [5:0]  dev = '0;
  logic        skip_o, illegal_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skip_eval i_skip_eval (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_i     (exec_i),
    .instr_i    (instr_i),
    .acc_i      (acc_i),
    .link_i     (link_i),
    .disp_run_i (dev[5]),
    .kbd_rdy_i  (dev[4]),
    .rx_rdy_i   (dev[3]),
    .tx_rdy_i   (dev[2]),
    .sync_i     (dev[1]),
    .tape_rdy_i (dev[0]),
    .skip_o     (skip_o),
    .illegal_o  (illegal_o)
  );

  task automatic check(input string req, input logic es, input logic ei);
    checks++;
    if (skip_o !== es || illegal_o !== ei) begin
      fails++;
      $display("FAIL %s: skip/illegal = %b/%b expected %b/%b", req, skip_o, illegal_o, es, ei);
    end
  endtask

  task automatic strobe(input logic [15:0] w, input logic [15:0] a,
                        input logic l, input logic [5:0] d);
    @(negedge clk);
    instr_i = w; acc_i = a; link_i = l; dev = d; exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 1'b0, 1'b0);

    for (int k = 0; k < NVEC; k++) begin
      strobe(VEC[k][40:25], VEC[k][24:9], VEC[k][8], VEC[k][7:2]);
      check($sformatf("R3-R8 vector %0d", k), VEC[k][1], VEC[k][0]);
      @(negedge clk);
      check($sformatf("R9 pulse end vector %0d", k), 1'b0, 1'b0);
    end

    // R10: link changes after the strobe edge, before sampling
    @(negedge clk);
    instr_i = 16'o002004; link_i = 1'b0; exec_i = 1'b1;
    @(posedge clk);
    #1 link_i = 1'b1; exec_i = 1'b0;
    @(negedge clk);
    check("R10 late link change", 1'b1, 1'b0);

    // R10 / R9: inputs toggling with strobe low produce nothing
    instr_i = 16'o002010; dev = 6'b100000;
    @(negedge clk);
    check("R10 no strobe", 1'b0, 1'b0);
    instr_i = 16'o002000;
    @(negedge clk);
    check("R9 no strobe malformed", 1'b0, 1'b0);

    // R11 / R8 back-to-back strobes: illegal then legal skip
    @(negedge clk);
    instr_i = 16'o002006; exec_i = 1'b1;
    @(negedge clk);
    check("R11 illegal first", 1'b0, 1'b1);
    instr_i = 16'o002400; dev = 6'b000001;
    @(negedge clk);
    exec_i = 1'b0;
    check("R11 skip second", 1'b1, 1'b0);

    // R1: reset in the middle of a pulse clears it
    strobe(16'o002001, 16'h0000, 1'b0, 6'b000000);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule